// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Core

This block is a small single-cycle processor for a 32-bit load/store instruction subset. In every clock in which it is enabled it reads one instruction word from its instruction memory, decodes it, executes it and retires it. All architectural state is updated at that one edge: the program counter, one register of the 32-entry register file, and one data-memory word. Only fifteen operations are decoded: register add, subtract and signed set-less-than; add, set-less-than, AND, OR and load-upper with an immediate; word load and store; equal and not-equal branches; absolute jump; jump-and-link; and jump through a register. Any other opcode retires as a no-op.

The instruction and data memories are word arrays inside the block, and data addressing is byte based. A load port fills both memories while the core is halted. A read port on the data memory lets the surrounding logic inspect results. The `run` input gates execution: while it is low, no state changes except through the load port.

Top module: `sc_core`

## Requirements
- R1: After reset the program counter is 0 and no register write is signalled. Every instruction that does not change the flow of control advances the program counter by 4.
- R2: With op field bits [31:26] equal to 0, the funct field bits [5:0] selects the operation: 32 is add, 34 is subtract (rs minus rt) and 42 is signed set-less-than. The result goes to rd in bits [15:11], rs is in bits [25:21] and rt is in bits [20:16].
- R3: Register 0 reads as zero in every instruction, and writes that target it have no effect.
- R4: Load word (op 35) writes rt with the data word at byte address rs plus the sign-extended immediate in bits [15:0]. Store word (op 43) writes rt's value to that address.
- R5: beq (op 4) and bne (op 5) compare rs and rt. When taken, the next PC is PC+4 plus the sign-extended immediate shifted left by 2, and a negative offset branches backwards.
- R6: j (op 2) and jal (op 3) go to {PC+4[31:28], bits [25:0], 2'b00}. jal also writes PC+4 to register 31 in the same cycle.
- R7: jr (op 0, funct 8) loads the program counter from register rs.
- R8: addi (op 8) and slti (op 10) sign-extend their immediate. andi (op 12) and ori (op 13) zero-extend theirs.
- R9: lui (op 15) writes the immediate into rt bits [31:16] and zeros into bits [15:0], so that a following ori can complete a 32-bit constant.
- R10: While `run` is low, the program counter and all registers keep their values and `wb_en_o` is 0.
- R11: The load port writes a word into data memory (`ld_dmem`=1) or instruction memory (`ld_dmem`=0) at word index `ld_addr`. Such a word is visible to a later lw or fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Execute one instruction per clock while high |
| ld_en | input | 1 | Load port write strobe |
| ld_dmem | input | 1 | Load target: 1 data memory, 0 instruction memory |
| ld_addr | input | MEM_AW | Load word index |
| ld_data | input | 32 | Load word |
| pk_addr | input | MEM_AW | Data memory inspection word index |
| pk_data | output | 32 | Data memory word at pk_addr |
| pc_o | output | 32 | Current program counter |
| wb_en_o | output | 1 | Register write in this cycle |
| wb_reg_o | output | 5 | Register written |
| wb_data_o | output | 32 | Value written (ALU result when no write) |

## Verification
The bench targets the corner cases in which operand extension differs. Examples are andi with an immediate that has its top bit set, and slti against -1. A core that sign-extended andi would produce 0xFFFF8001 instead of 0x00008001. The bench also checks a store with a negative displacement and a backward branch to itself, either of which would be lost by unsigned offset arithmetic. It also checks writes to register 0, which a careless register file would keep and then return. Jump-and-link and jump-register are chained so that a wrong link value (PC instead of PC+4) or a wrong jump target field breaks the whole sequence. A pause of `run` in mid-program exposes a PC that creeps forward while halted.

// File: rtl/sc_pkg.sv
package sc_pkg;
    localparam int XLEN = 32;
    localparam int NREG = 32;

    localparam logic [5:0] OP_REG  = 6'd0;
    localparam logic [5:0] OP_J    = 6'd2;
    localparam logic [5:0] OP_JAL  = 6'd3;
    localparam logic [5:0] OP_BEQ  = 6'd4;
    localparam logic [5:0] OP_BNE  = 6'd5;
    localparam logic [5:0] OP_ADDI = 6'd8;
    localparam logic [5:0] OP_SLTI = 6'd10;
    localparam logic [5:0] OP_ANDI = 6'd12;
    localparam logic [5:0] OP_ORI  = 6'd13;
    localparam logic [5:0] OP_LUI  = 6'd15;
    localparam logic [5:0] OP_LW   = 6'd35;
    localparam logic [5:0] OP_SW   = 6'd43;

    localparam logic [5:0] FN_JR  = 6'd8;
    localparam logic [5:0] FN_ADD = 6'd32;
    localparam logic [5:0] FN_SUB = 6'd34;
    localparam logic [5:0] FN_SLT = 6'd42;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_SLT, ALU_AND, ALU_OR, ALU_UPPER
    } alu_op_e;

    typedef enum logic [1:0] {
        DST_RT, DST_RD, DST_LINK
    } dst_e;

    typedef struct packed {
        alu_op_e alu_op;
        logic    b_imm;
        logic    imm_zext;
        logic    reg_we;
        dst_e    dst;
        logic    mem_we;
        logic    mem_rd;
        logic    br_eq;
        logic    br_ne;
        logic    jmp;
        logic    link;
        logic    jreg;
    } ctrl_t;

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } core_state_t;
endpackage

// File: rtl/sc_wordmem.sv
module sc_wordmem #(
    parameter int AW   = 6,
    parameter int DW   = 32,
    parameter int N_RD = 2
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [AW-1:0]           wa,
    input  logic [DW-1:0]           wd,
    input  logic [N_RD-1:0][AW-1:0] rd_addr,
    output logic [N_RD-1:0][DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[wa] <= wd;
        end
    end

    for (genvar p = 0; p < N_RD; p++) begin : g_rd
        assign rd_data[p] = mem_q[rd_addr[p]];
    end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int NREG = 32,
    parameter int XLEN = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(NREG)-1:0]  ra,
    input  logic [$clog2(NREG)-1:0]  rb,
    output logic [XLEN-1:0]          rda,
    output logic [XLEN-1:0]          rdb,
    input  logic                     we,
    input  logic [$clog2(NREG)-1:0]  wa,
    input  logic [XLEN-1:0]          wd
);
    localparam int AW = $clog2(NREG);

    logic [XLEN-1:0] regs_q [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                regs_q[i] <= '0;
            end
        end else if (we && (wa != AW'(0))) begin
            regs_q[wa] <= wd;
        end
    end

    assign rda = (ra == AW'(0)) ? '0 : regs_q[ra];
    assign rdb = (rb == AW'(0)) ? '0 : regs_q[rb];
endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   y
);
    localparam int HALF = W / 2;

    always_comb begin
        unique case (op)
            ALU_ADD:   y = a + b;
            ALU_SUB:   y = a - b;
            ALU_SLT:   y = ($signed(a) < $signed(b)) ? W'(1) : '0;
            ALU_AND:   y = a & b;
            ALU_OR:    y = a | b;
            ALU_UPPER: y = {b[HALF-1:0], {HALF{1'b0}}};
            default:   y = '0;
        endcase
    end
endmodule

// File: rtl/sc_decode.sv
module sc_decode
    import sc_pkg::*;
(
    input  logic [5:0] op,
    input  logic [5:0] funct,
    output ctrl_t      ctl
);
    always_comb begin
        ctl        = '0;
        ctl.alu_op = ALU_ADD;
        ctl.dst    = DST_RT;
        unique case (op)
            OP_REG: begin
                ctl.dst = DST_RD;
                unique case (funct)
                    FN_ADD: begin ctl.alu_op = ALU_ADD; ctl.reg_we = 1'b1; end
                    FN_SUB: begin ctl.alu_op = ALU_SUB; ctl.reg_we = 1'b1; end
                    FN_SLT: begin ctl.alu_op = ALU_SLT; ctl.reg_we = 1'b1; end
                    FN_JR:  ctl.jreg = 1'b1;
                    default: ;
                endcase
            end
            OP_ADDI: begin ctl.b_imm = 1'b1; ctl.reg_we = 1'b1; end
            OP_SLTI: begin ctl.b_imm = 1'b1; ctl.reg_we = 1'b1; ctl.alu_op = ALU_SLT; end
            OP_ANDI: begin
                ctl.b_imm = 1'b1; ctl.imm_zext = 1'b1; ctl.reg_we = 1'b1; ctl.alu_op = ALU_AND;
            end
            OP_ORI: begin
                ctl.b_imm = 1'b1; ctl.imm_zext = 1'b1; ctl.reg_we = 1'b1; ctl.alu_op = ALU_OR;
            end
            OP_LUI: begin
                ctl.b_imm = 1'b1; ctl.imm_zext = 1'b1; ctl.reg_we = 1'b1; ctl.alu_op = ALU_UPPER;
            end
            OP_LW:  begin ctl.b_imm = 1'b1; ctl.reg_we = 1'b1; ctl.mem_rd = 1'b1; end
            OP_SW:  begin ctl.b_imm = 1'b1; ctl.mem_we = 1'b1; end
            OP_BEQ: ctl.br_eq = 1'b1;
            OP_BNE: ctl.br_ne = 1'b1;
            OP_J:   ctl.jmp = 1'b1;
            OP_JAL: begin
                ctl.jmp = 1'b1; ctl.link = 1'b1; ctl.reg_we = 1'b1; ctl.dst = DST_LINK;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter int MEM_AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              ld_en,
    input  logic              ld_dmem,
    input  logic [MEM_AW-1:0] ld_addr,
    input  logic [31:0]       ld_data,
    input  logic [MEM_AW-1:0] pk_addr,
    output logic [31:0]       pk_data,
    output logic [31:0]       pc_o,
    output logic              wb_en_o,
    output logic [4:0]        wb_reg_o,
    output logic [31:0]       wb_data_o
);
    localparam int RAW      = $clog2(NREG);
    localparam int IMM_W    = 16;
    localparam int TGT_W    = 26;
    localparam int REGION_W = XLEN - TGT_W - 2;
    localparam logic [RAW-1:0] LINK_REG = RAW'(NREG - 1);

    core_state_t st_q, st_d;

    logic [XLEN-1:0]  instr;
    logic [5:0]       f_op, f_funct;
    logic [RAW-1:0]   f_rs, f_rt, f_rd;
    logic [IMM_W-1:0] f_imm;
    logic [TGT_W-1:0] f_tgt;
    ctrl_t            ctl;

    logic [XLEN-1:0]  rs_val, rt_val, imm_ext, alu_b, alu_y, ld_word;
    logic [XLEN-1:0]  pc_plus4, br_target, jmp_target, next_pc;
    logic             br_taken;
    logic             rf_we;
    logic [RAW-1:0]   rf_wa;
    logic [XLEN-1:0]  rf_wd;

    logic              dm_we;
    logic [MEM_AW-1:0] dm_wa;
    logic [XLEN-1:0]   dm_wd;
    logic [1:0][MEM_AW-1:0] dm_ra;
    logic [1:0][XLEN-1:0]   dm_rd;
    logic [0:0][MEM_AW-1:0] im_ra;
    logic [0:0][XLEN-1:0]   im_rd;

    // Memories
    assign im_ra[0] = st_q.pc[MEM_AW+1:2];
    assign instr    = im_rd[0];

    sc_wordmem #(.AW(MEM_AW), .DW(XLEN), .N_RD(1)) u_imem (
        .clk     (clk),
        .we      (ld_en && !ld_dmem),
        .wa      (ld_addr),
        .wd      (ld_data),
        .rd_addr (im_ra),
        .rd_data (im_rd)
    );

    assign dm_we    = (ld_en && ld_dmem) || (run && ctl.mem_we);
    assign dm_wa    = (ld_en && ld_dmem) ? ld_addr : alu_y[MEM_AW+1:2];
    assign dm_wd    = (ld_en && ld_dmem) ? ld_data : rt_val;
    assign dm_ra[0] = alu_y[MEM_AW+1:2];
    assign dm_ra[1] = pk_addr;
    assign ld_word  = dm_rd[0];
    assign pk_data  = dm_rd[1];

    sc_wordmem #(.AW(MEM_AW), .DW(XLEN), .N_RD(2)) u_dmem (
        .clk     (clk),
        .we      (dm_we),
        .wa      (dm_wa),
        .wd      (dm_wd),
        .rd_addr (dm_ra),
        .rd_data (dm_rd)
    );

    // Field split and decode
    assign f_op    = instr[31:26];
    assign f_rs    = instr[25:21];
    assign f_rt    = instr[20:16];
    assign f_rd    = instr[15:11];
    assign f_funct = instr[5:0];
    assign f_imm   = instr[IMM_W-1:0];
    assign f_tgt   = instr[TGT_W-1:0];

    sc_decode u_dec (
        .op    (f_op),
        .funct (f_funct),
        .ctl   (ctl)
    );

    sc_regfile #(.NREG(NREG), .XLEN(XLEN)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra    (f_rs),
        .rb    (f_rt),
        .rda   (rs_val),
        .rdb   (rt_val),
        .we    (rf_we),
        .wa    (rf_wa),
        .wd    (rf_wd)
    );

    assign imm_ext = ctl.imm_zext ? {{(XLEN-IMM_W){1'b0}}, f_imm}
                                  : {{(XLEN-IMM_W){f_imm[IMM_W-1]}}, f_imm};
    assign alu_b   = ctl.b_imm ? imm_ext : rt_val;

    sc_alu #(.W(XLEN)) u_alu (
        .op (ctl.alu_op),
        .a  (rs_val),
        .b  (alu_b),
        .y  (alu_y)
    );

    // Next-state and writeback
    always_comb begin
        pc_plus4   = st_q.pc + XLEN'(4);
        br_target  = pc_plus4 + {{(XLEN-IMM_W-2){f_imm[IMM_W-1]}}, f_imm, 2'b00};
        jmp_target = {pc_plus4[XLEN-1 -: REGION_W], f_tgt, 2'b00};
        br_taken   = (ctl.br_eq && (rs_val == rt_val)) || (ctl.br_ne && (rs_val != rt_val));

        if (ctl.jreg)      next_pc = rs_val;
        else if (ctl.jmp)  next_pc = jmp_target;
        else if (br_taken) next_pc = br_target;
        else               next_pc = pc_plus4;

        unique case (ctl.dst)
            DST_RD:   rf_wa = f_rd;
            DST_LINK: rf_wa = LINK_REG;
            default:  rf_wa = f_rt;
        endcase
        if (ctl.link)        rf_wd = pc_plus4;
        else if (ctl.mem_rd) rf_wd = ld_word;
        else                 rf_wd = alu_y;
        rf_we = run && ctl.reg_we;

        st_d = st_q;
        if (run) begin
            st_d.pc = next_pc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_o      = st_q.pc;
    assign wb_en_o   = rf_we;
    assign wb_reg_o  = rf_wa;
    assign wb_data_o = rf_wd;

    // Assertions
    assert_pc_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !ctl.jreg && !ctl.jmp && !ctl.br_eq && !ctl.br_ne)
            |=> (st_q.pc == $past(st_q.pc) + XLEN'(4)));

    assert_r0_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (f_rs == '0) |-> (rs_val == '0));

    assert_store_no_wb_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && ctl.mem_we) |-> !wb_en_o);

    assert_flow_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({br_taken, ctl.jmp, ctl.jreg}));

    assert_jump_region_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && ctl.jmp) |=> (st_q.pc[XLEN-1 -: REGION_W] == $past(pc_plus4[XLEN-1 -: REGION_W]))
                          && (st_q.pc[TGT_W+1:2] == $past(f_tgt)));

    assert_link_reg_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && ctl.link) |-> (wb_en_o && (wb_reg_o == LINK_REG)));

    assert_jr_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && ctl.jreg) |=> (st_q.pc == $past(rs_val)));

    assert_pc_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(st_q.pc));
endmodule

// File: tb/sc_core_bench.sv
module sc_core_bench;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run = 1'b0;
    logic          ld_en = 1'b0;
    logic          ld_dmem = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [31:0]   ld_data = '0;
    logic [AW-1:0] pk_addr = '0;
    logic [31:0]   pk_data, pc_o, wb_data_o;
    logic          wb_en_o;
    logic [4:0]    wb_reg_o;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    sc_core #(.MEM_AW(AW)) u_sc_core (
        .clk(clk), .rst_n(rst_n), .run(run),
        .ld_en(ld_en), .ld_dmem(ld_dmem), .ld_addr(ld_addr), .ld_data(ld_data),
        .pk_addr(pk_addr), .pk_data(pk_data),
        .pc_o(pc_o), .wb_en_o(wb_en_o), .wb_reg_o(wb_reg_o), .wb_data_o(wb_data_o)
    );

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input int fn);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
    endfunction
    function automatic logic [31:0] enc_i(input int op, input int rs, input int rt, input int imm);
        return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
    endfunction
    function automatic logic [31:0] enc_j(input int op, input int tgt);
        return {6'(op), 26'(tgt)};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; run = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic load(input logic to_dmem, input int idx, input logic [31:0] w);
        @(negedge clk);
        ld_en = 1'b1; ld_dmem = to_dmem; ld_addr = AW'(idx); ld_data = w;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic run_n(input int n);
        @(negedge clk);
        run = 1'b1;
        repeat (n) @(negedge clk);
        run = 1'b0;
        #1;
    endtask

    task automatic peek_chk(input string req, input int idx, input logic [31:0] exp);
        pk_addr = AW'(idx);
        #1;
        chk(req, pk_data, exp);
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        chk("R1 pc after reset", pc_o, 32'd0);
        chk("R1 no write after reset", {31'd0, wb_en_o}, 32'd0);
    endtask

    task automatic t_rtype_pause();
        do_reset();
        load(0, 0, enc_i(8, 0, 1, 7));
        load(0, 1, enc_i(8, 0, 2, -3));
        load(0, 2, enc_r(1, 2, 3, 32));
        load(0, 3, enc_r(2, 1, 4, 34));
        load(0, 4, enc_r(2, 1, 5, 42));
        load(0, 5, enc_r(1, 2, 6, 42));
        load(0, 6, enc_i(43, 0, 3, 0));
        load(0, 7, enc_i(43, 0, 4, 4));
        load(0, 8, enc_i(43, 0, 5, 8));
        load(0, 9, enc_i(43, 0, 6, 12));
        load(0, 10, enc_i(4, 0, 0, -1));
        run_n(5);
        chk("R1 pc after 5 steps", pc_o, 32'd20);
        chk("R10 no write while halted", {31'd0, wb_en_o}, 32'd0);
        repeat (4) @(negedge clk);
        #1;
        chk("R10 pc held while halted", pc_o, 32'd20);
        run_n(5);
        peek_chk("R2 add", 0, 32'd4);
        peek_chk("R2 sub", 1, 32'hFFFF_FFF6);
        peek_chk("R2 slt true", 2, 32'd1);
        peek_chk("R2 slt false", 3, 32'd0);
    endtask

    task automatic t_reg0();
        do_reset();
        load(1, 6, 32'hFFFF_FFFF);
        load(1, 7, 32'hFFFF_FFFF);
        load(0, 0, enc_i(8, 0, 0, 5));
        load(0, 1, enc_i(15, 0, 0, 16'h1234));
        load(0, 2, enc_r(0, 0, 1, 32));
        load(0, 3, enc_i(43, 0, 1, 24));
        load(0, 4, enc_i(43, 0, 0, 28));
        load(0, 5, enc_i(4, 0, 0, -1));
        run_n(6);
        peek_chk("R3 r0 read after write", 6, 32'd0);
        peek_chk("R3 r0 stored", 7, 32'd0);
    endtask

    task automatic t_imm();
        do_reset();
        load(0, 0, enc_i(13, 0, 1, 16'h8001));
        load(0, 1, enc_i(8, 0, 3, -1));
        load(0, 2, enc_i(12, 3, 2, 16'h8001));
        load(0, 3, enc_i(10, 3, 4, 0));
        load(0, 4, enc_i(10, 1, 5, -1));
        load(0, 5, enc_i(15, 0, 6, 16'hABCD));
        load(0, 6, enc_i(13, 6, 6, 16'h1234));
        load(0, 7, enc_i(43, 0, 1, 0));
        load(0, 8, enc_i(43, 0, 2, 4));
        load(0, 9, enc_i(43, 0, 4, 8));
        load(0, 10, enc_i(43, 0, 5, 12));
        load(0, 11, enc_i(43, 0, 6, 16));
        load(0, 12, enc_i(4, 0, 0, -1));
        run_n(12);
        peek_chk("R8 ori zero-extends", 0, 32'h0000_8001);
        peek_chk("R8 andi zero-extends", 1, 32'h0000_8001);
        peek_chk("R8 slti -1<0", 2, 32'd1);
        peek_chk("R8 slti sign-extended imm", 3, 32'd0);
        peek_chk("R9 lui then ori", 4, 32'hABCD_1234);
    endtask

    task automatic t_mem();
        do_reset();
        load(1, 20, 32'hCAFE_F00D);
        load(0, 0, enc_i(8, 0, 1, 40));
        load(0, 1, enc_i(8, 0, 2, 16'h55));
        load(0, 2, enc_i(43, 1, 2, -8));
        load(0, 3, enc_i(35, 1, 3, -8));
        load(0, 4, enc_i(8, 3, 3, 1));
        load(0, 5, enc_i(43, 1, 3, 4));
        load(0, 6, enc_i(35, 0, 4, 80));
        load(0, 7, enc_i(43, 0, 4, 84));
        load(0, 8, enc_i(4, 0, 0, -1));
        run_n(8);
        peek_chk("R4 store negative offset", 8, 32'h55);
        peek_chk("R4 load then store", 11, 32'h56);
        peek_chk("R11 preloaded word read by lw", 21, 32'hCAFE_F00D);
    endtask

    task automatic t_branch();
        do_reset();
        load(1, 0, 32'd0);
        load(0, 0, enc_i(8, 0, 1, 1));
        load(0, 1, enc_i(4, 1, 0, 1));
        load(0, 2, enc_i(8, 0, 2, 9));
        load(0, 3, enc_i(5, 1, 0, 1));
        load(0, 4, enc_i(8, 0, 2, 99));
        load(0, 5, enc_i(43, 0, 2, 0));
        load(0, 6, enc_i(4, 0, 0, -1));
        run_n(7);
        peek_chk("R5 bne taken skips, beq not taken falls through", 0, 32'd9);
        chk("R5 backward branch to self", pc_o, 32'd24);
    endtask

    task automatic t_jump();
        do_reset();
        load(1, 0, 32'd0);
        load(0, 0, enc_j(3, 4));
        load(0, 1, enc_i(43, 0, 31, 0));
        load(0, 2, enc_j(2, 6));
        load(0, 3, enc_i(8, 0, 5, 77));
        load(0, 4, enc_r(31, 0, 0, 8));
        load(0, 5, enc_i(43, 0, 5, 4));
        load(0, 6, enc_i(4, 0, 0, -1));
        @(negedge clk);
        run = 1'b1;
        #1;
        chk("R6 jal write strobe", {31'd0, wb_en_o}, 32'd1);
        chk("R6 jal link register", {27'd0, wb_reg_o}, 32'd31);
        chk("R6 jal link value", wb_data_o, 32'd4);
        @(negedge clk);
        #1;
        chk("R6 jal target", pc_o, 32'd16);
        @(negedge clk);
        #1;
        chk("R7 jr target", pc_o, 32'd4);
        repeat (3) @(negedge clk);
        run = 1'b0;
        #1;
        chk("R6 j target", pc_o, 32'd24);
        peek_chk("R6 stored link", 0, 32'd4);
    endtask

    initial begin
        t_reset();
        t_rtype_pause();
        t_reg0();
        t_imm();
        t_mem();
        t_branch();
        t_jump();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 200000);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule